// File: doc/BRIEF.md
# Iterative Decimal Multiplier

This block multiplies two unsigned decimal numbers of `NDIG` BCD digits each and returns the full product of `2*NDIG` BCD digits. The multiplier operand is used one digit per clock, least significant digit first. In each cycle a row of `NDIG` single-digit decimal multipliers forms the product of the whole multiplicand and one multiplier digit. The two-digit results of that row are merged into one partial product of `NDIG+1` digits. That partial product is then added into a running decimal accumulator. The accumulator moves one digit to the right on each step and retires one finished low-order product digit.

Partial-product generation and accumulation sit in two register stages. The last accumulation of one operation therefore takes place in the same cycle as the first partial product of the next one. A product appears `NDIG+1` cycles after its operands are taken, and a new operation can be taken every `NDIG` cycles. The user offers operands with `start_i` while `ready_o` is high, and collects the product on the one-cycle `valid_o` pulse. Operands that contain a digit code above nine still run to completion. In that case `err_o` is raised with the pulse.

Top module: `bcd_iter_mul`

## Requirements
- R1: While reset is held and afterwards until the first start is taken, `ready_o` is 1 and `valid_o`, `err_o` and `product_o` are 0.
- R2: For operands whose digits are all 0..9, `product_o` equals the decimal product of the two operands. The product has 2*NDIG BCD digits. Digit i of every port occupies bits 4i+3..4i, and the least significant digit is at bits 3..0.
- R3: `valid_o` is high right after the (NDIG+1)th rising edge that follows the edge on which the operands were taken. Every accepted operation produces exactly one such pulse.
- R4: After an acceptance, `ready_o` is low for NDIG-1 cycles and then high again. This lets successive operations be accepted exactly NDIG edges apart, and each of those back-to-back products is still correct.
- R5: A `start_i` asserted while `ready_o` is low is ignored. It captures no operands and produces no extra `valid_o` pulse.
- R6: `valid_o` lasts exactly one cycle per operation. `product_o` and `err_o` hold their values between pulses.
- R7: If any digit of either operand has a code from 10 to 15, the operation still completes with the normal latency and `err_o` is 1 during its pulse. For all-valid operands, `err_o` is 0 during the pulse.
- R8: Decimal correction keeps every digit of the partial products, of the accumulator and of the product within 0..9, and no carry is lost. Multiplying two all-nines operands gives nines in the top NDIG-1 digits, then 8, then NDIG-1 zeros, then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Offer operands; taken on an edge where ready_o is high |
| mcand_i | input | 4*NDIG | Multiplicand, BCD |
| mplier_i | input | 4*NDIG | Multiplier, BCD, consumed least significant digit first |
| ready_o | output | 1 | Operands can be taken on the next edge |
| valid_o | output | 1 | One-cycle pulse marking a finished product |
| product_o | output | 8*NDIG | BCD product, held between pulses |
| err_o | output | 1 | The finished operation had a non-decimal operand digit |

## Verification
Zero operands show that the accumulator starts clean and leaves no residue from an earlier operation. Two all-nines operands drive a carry into every digit adder, so they separate correct decimal correction from a missing add-six or a dropped carry. Mixed-digit, single-digit and random operands test digit alignment and the order of the right shift. Back-to-back issue and start pulses sent while busy test the overlap of the last accumulation with the next first partial product, and the ignoring of starts that arrive too early. Operands with codes 10 to 15 placed at random positions check that the error flag stays with its own operation while operations before and after it come out clean.

// File: rtl/bcd_mul_pkg.sv
package bcd_mul_pkg;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        logic cout;
        bcd_t sum;
    } dsum_t;

    // Tag that travels with a partial product down the pipeline
    typedef struct packed {
        logic first;
        logic last;
        logic err;
    } pp_tag_t;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_t;

    // One decimal digit adder with add-six correction
    function automatic dsum_t bcd_dadd(input bcd_t a, input bcd_t b, input logic cin);
        logic [4:0] s;
        dsum_t r;
        s = {1'b0, a} + {1'b0, b} + {4'd0, cin};
        if (s > 5'd9) begin
            r.sum  = 4'(s + 5'd6);
            r.cout = 1'b1;
        end else begin
            r.sum  = s[3:0];
            r.cout = 1'b0;
        end
        return r;
    endfunction

    function automatic logic bcd_ok(input bcd_t d);
        return d <= 4'd9;
    endfunction

endpackage

// File: rtl/bcd_digit_mul.sv
module bcd_digit_mul
    import bcd_mul_pkg::*;
(
    input  bcd_t x_i,
    input  bcd_t y_i,
    output bcd_t tens_o,
    output bcd_t ones_o
);
    logic [7:0] bin;
    logic [7:0] low2;

    // Binary product reduced mod 100 so both output digits stay decimal
    always_comb begin
        bin    = {4'd0, x_i} * {4'd0, y_i};
        low2   = bin % 8'd100;
        tens_o = 4'(low2 / 8'd10);
        ones_o = 4'(low2 % 8'd10);
    end
endmodule

// File: rtl/bcd_add_n.sv
module bcd_add_n
    import bcd_mul_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int W = 4 * NDIG
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic  [NDIG:0] carry;
    dsum_t          dig [NDIG];

    assign carry[0] = cin_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign dig[g]          = bcd_dadd(a_i[4*g +: 4], b_i[4*g +: 4], carry[g]);
        assign sum_o[4*g +: 4] = dig[g].sum;
        assign carry[g+1]      = dig[g].cout;
    end

    assign cout_o = carry[NDIG];
endmodule

// File: rtl/bcd_pp_stage.sv
module bcd_pp_stage
    import bcd_mul_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int W  = 4 * NDIG,
    localparam int WP = 4 * (NDIG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [W-1:0]  mcand_i,
    input  bcd_t          digit_i,
    input  pp_tag_t       tag_i,
    output logic          vld_o,
    output logic [WP-1:0] pp_o,
    output pp_tag_t       tag_o
);
    logic [W-1:0]  ones_v;
    logic [W-1:0]  tens_v;
    logic [WP-1:0] merged;
    logic          merge_cout;

    // One single-digit multiplier per multiplicand digit
    for (genvar g = 0; g < NDIG; g++) begin : g_mul
        bcd_digit_mul u_dm (
            .x_i    (mcand_i[4*g +: 4]),
            .y_i    (digit_i),
            .tens_o (tens_v[4*g +: 4]),
            .ones_o (ones_v[4*g +: 4])
        );
    end

    // Tens digits sit one place above their ones digits
    bcd_add_n #(.NDIG(NDIG + 1)) u_merge (
        .a_i    ({4'd0, ones_v}),
        .b_i    ({tens_v, 4'd0}),
        .cin_i  (1'b0),
        .sum_o  (merged),
        .cout_o (merge_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            pp_o  <= '0;
            tag_o <= '0;
        end else begin
            vld_o <= en_i;
            if (en_i) begin
                pp_o  <= merged;
                tag_o <= tag_i;
            end
        end
    end

    AST_PP_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (en_i && !tag_i.err) |-> !merge_cout); // R8
endmodule

// File: rtl/bcd_iter_mul.sv
module bcd_iter_mul
    import bcd_mul_pkg::*;
#(
    parameter int NDIG = 8,
    localparam int W  = 4 * NDIG,
    localparam int WP = 4 * (NDIG + 1),
    localparam int CW = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           ready_o,
    output logic           valid_o,
    output logic [2*W-1:0] product_o,
    output logic           err_o
);
    localparam logic [CW-1:0] LAST_CNT = CW'(NDIG - 1);

    // ---------------- issue and digit sequencing ----------------
    gen_state_t    gen_st;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  mcand_q;
    logic [W-1:0]  mplier_q;
    logic          op_err_q;
    logic          in_bad;
    logic          accept;
    logic          gen_en;
    logic          gen_last;
    pp_tag_t       gen_tag;

    always_comb begin
        in_bad = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            if (!bcd_ok(mcand_i[4*i +: 4]) || !bcd_ok(mplier_i[4*i +: 4]))
                in_bad = 1'b1;
        end
    end

    assign gen_en   = (gen_st == GEN_RUN);
    assign gen_last = gen_en && (cnt_q == LAST_CNT);
    assign ready_o  = !gen_en || gen_last;
    assign accept   = start_i && ready_o;

    always_comb begin
        gen_tag.first = (cnt_q == '0);
        gen_tag.last  = (cnt_q == LAST_CNT);
        gen_tag.err   = op_err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_st   <= GEN_IDLE;
            cnt_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            op_err_q <= 1'b0;
        end else begin
            if (gen_en) begin
                mplier_q <= {4'd0, mplier_q[W-1:4]};
                cnt_q    <= cnt_q + CW'(1);
                if (gen_last)
                    gen_st <= GEN_IDLE;
            end
            if (accept) begin
                mcand_q  <= mcand_i;
                mplier_q <= mplier_i;
                cnt_q    <= '0;
                op_err_q <= in_bad;
                gen_st   <= GEN_RUN;
            end
        end
    end

    // ---------------- partial product stage ----------------
    logic          pp_vld;
    logic [WP-1:0] pp_q;
    pp_tag_t       pp_tag;

    bcd_pp_stage #(.NDIG(NDIG)) u_pp (
        .clk     (clk),
        .rst     (rst),
        .en_i    (gen_en),
        .mcand_i (mcand_q),
        .digit_i (mplier_q[3:0]),
        .tag_i   (gen_tag),
        .vld_o   (pp_vld),
        .pp_o    (pp_q),
        .tag_o   (pp_tag)
    );

    // ---------------- accumulation stage ----------------
    logic [W-1:0]   acc_q;
    logic [W-1:0]   lo_q;
    logic [W-1:0]   acc_in;
    logic [WP-1:0]  acc_sum;
    logic           acc_cout;
    logic [2*W-1:0] prod_q;
    logic           valid_q;
    logic           err_q;

    assign acc_in = pp_tag.first ? '0 : acc_q;

    bcd_add_n #(.NDIG(NDIG + 1)) u_acc (
        .a_i    ({4'd0, acc_in}),
        .b_i    (pp_q),
        .cin_i  (1'b0),
        .sum_o  (acc_sum),
        .cout_o (acc_cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            lo_q    <= '0;
            prod_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (pp_vld) begin
                acc_q <= acc_sum[WP-1:4];
                lo_q  <= {acc_sum[3:0], lo_q[W-1:4]};
                if (pp_tag.last) begin
                    prod_q  <= {acc_sum, lo_q[W-1:4]};
                    valid_q <= 1'b1;
                    err_q   <= pp_tag.err;
                end
            end
        end
    end

    assign valid_o   = valid_q;
    assign product_o = prod_q;
    assign err_o     = err_q;

    // ---------------- assertions ----------------
    logic prod_digits_ok;
    logic lo_digits_ok;

    always_comb begin
        prod_digits_ok = 1'b1;
        for (int i = 0; i < 2*NDIG; i++)
            if (!bcd_ok(prod_q[4*i +: 4])) prod_digits_ok = 1'b0;
        lo_digits_ok = 1'b1;
        for (int i = 0; i < NDIG; i++)
            if (!bcd_ok(lo_q[4*i +: 4])) lo_digits_ok = 1'b0;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R6

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (accept && NDIG > 1) |=> !ready_o); // R4

    AST_PROD_DIGITS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o) |-> prod_digits_ok); // R2

    AST_ACC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (pp_vld && !pp_tag.err) |-> !acc_cout); // R8

    AST_LO_DIGITS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o) |-> lo_digits_ok); // R8

    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(product_o)); // R6
endmodule

// File: tb/sim_bcd_iter_mul.sv
module sim_bcd_iter_mul;
    localparam int N = 8;
    localparam int W = 4 * N;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   ma = '0;
    logic [W-1:0]   mb = '0;
    logic           ready;
    logic           valid;
    logic           err;
    logic [2*W-1:0] prod;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_acc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        int           at;
    } op_t;
    op_t q[$];

    bcd_iter_mul #(.NDIG(N)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .mcand_i   (ma),
        .mplier_i  (mb),
        .ready_o   (ready),
        .valid_o   (valid),
        .product_o (prod),
        .err_o     (err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit has_bad(logic [W-1:0] v);
        for (int i = 0; i < N; i++) if (v[4*i +: 4] > 4'd9) return 1'b1;
        return 1'b0;
    endfunction

    function automatic longint unsigned to_int(logic [W-1:0] v);
        longint unsigned r = 0;
        for (int i = N - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [2*W-1:0] to_bcd(longint unsigned x);
        logic [2*W-1:0] r = '0;
        for (int i = 0; i < 2*N; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_bcd();
        logic [W-1:0] r;
        for (int i = 0; i < N; i++) r[4*i +: 4] = 4'($urandom_range(9));
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic issue(logic [W-1:0] a, logic [W-1:0] b);
        ma = a;
        mb = b;
        start = 1'b1;
        while (!ready) @(negedge clk);
        q.push_back('{a: a, b: b, at: cyc + 1});
        last_acc = cyc + 1;
        @(negedge clk);
    endtask

    task automatic idle(int k);
        start = 1'b0;
        repeat (k) @(negedge clk);
    endtask

    // Output monitor
    logic           prev_valid = 1'b0;
    logic [2*W-1:0] prev_prod = '0;
    logic           prev_err = 1'b0;
    op_t            mop;
    bit             mbad;
    logic [2*W-1:0] mexp;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                check(!prev_valid, "R6", "valid wider than one cycle", 128'(prev_valid), 128'(0));
                if (q.size() == 0) begin
                    check(1'b0, "R5", "valid without an accepted operation", 128'(1), 128'(0));
                end else begin
                    mop  = q.pop_front();
                    mbad = has_bad(mop.a) || has_bad(mop.b);
                    check(cyc == mop.at + N + 1, "R3", "latency in cycles",
                          128'(cyc - mop.at), 128'(N + 1));
                    check(err == mbad, "R7", "error flag", 128'(err), 128'(mbad));
                    if (!mbad) begin
                        mexp = to_bcd(to_int(mop.a) * to_int(mop.b));
                        check(prod == mexp, "R2", "product", 128'(prod), 128'(mexp));
                    end
                end
            end else begin
                check(prod == prev_prod && err == prev_err, "R6", "outputs changed without valid",
                      128'(prod), 128'(prev_prod));
            end
            prev_valid = valid;
            prev_prod  = prod;
            prev_err   = err;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog expired: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int t0;
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        seed = $urandom(32'd4711);

        repeat (5) @(negedge clk);
        // R1: reset state while reset is held
        check(ready == 1'b1 && valid == 1'b0, "R1", "ready/valid in reset",
              128'({ready, valid}), 128'(2'b10));
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1, "R1", "ready after reset", 128'(ready), 128'(1));
        check(valid == 1'b0, "R1", "valid after reset", 128'(valid), 128'(0));
        check(prod == '0, "R1", "product after reset", 128'(prod), 128'(0));
        check(err == 1'b0, "R1", "err after reset", 128'(err), 128'(0));

        // R2: directed operands, zero and mixed digits
        issue('0, '0);
        idle(N + 2);
        // R8: all nines exercise every decimal carry
        issue({N{4'h9}}, {N{4'h9}});
        idle(N + 2);
        issue(32'h12345678, 32'h87654321);
        idle(3);
        issue(32'h00000001, 32'h90817263);
        idle(1);
        issue(32'h50000000, 32'h00000002);
        idle(N + 2);

        // R4: back-to-back issue, accept spacing must be N edges
        issue(32'h11111111, 32'h99999999);
        t0 = last_acc;
        for (int k = 0; k < 4; k++) begin
            issue(rnd_bcd(), rnd_bcd());
            check(last_acc - t0 == N, "R4", "back-to-back accept spacing",
                  128'(last_acc - t0), 128'(N));
            t0 = last_acc;
        end
        idle(N + 3);

        // R5: start pulses while busy must be ignored
        issue(32'h24681357, 32'h13572468);
        for (int k = 0; k < N - 2; k++) begin
            ma = rnd_bcd();
            mb = rnd_bcd();
            start = 1'b1;
            check(!ready, "R5", "ready low while busy", 128'(ready), 128'(0));
            @(negedge clk);
        end
        idle(2 * N + 4);
        check(q.size() == 0, "R5", "operations outstanding after ignored starts",
              128'(q.size()), 128'(0));

        // R7: non-decimal digit codes in either operand
        issue(32'h1234A678, 32'h11111111);
        idle(1);
        issue(32'h22222222, 32'hF0000000);
        issue(32'h33333333, 32'h00000003);
        idle(N + 3);

        // Random mix of valid and faulty operands, random gaps
        for (int k = 0; k < 300; k++) begin
            ra = rnd_bcd();
            rb = rnd_bcd();
            if ($urandom_range(9) == 0) ra[4*$urandom_range(N-1) +: 4] = 4'(10 + $urandom_range(5));
            if ($urandom_range(9) == 0) rb[4*$urandom_range(N-1) +: 4] = 4'(10 + $urandom_range(5));
            issue(ra, rb);
            if ($urandom_range(2) != 0) idle(int'($urandom_range(3)));
        end

        idle(2 * N + 4);
        check(q.size() == 0, "R3", "every accepted operation produced a result",
              128'(q.size()), 128'(0));
        done = 1'b1;
        summary();
        $finish;
    end
endmodule